// File: doc/BRIEF.md
# MII Transmit 4B5B Symbol Encoder

This block sits in the transmit path of a 100 Mbps Ethernet PHY. It runs on the transmit nibble clock, which is 25 MHz at 100 Mbps. On each clock it takes one nibble and its qualifiers from the MAC-facing side. One cycle later it presents a 5-bit code group to the serializer that follows it. A nibble that is qualified by the enable becomes its 4B5B data code group. An error that arrives with the enable at 100 Mbps turns that slot into the HALT group. A cycle without the enable becomes the IDLE group.

There is also a raw pass-through mode, in which the encoder is bypassed. In that mode the error input is used as a fifth data bit, the top bit. The upstream logic then supplies complete 5-bit symbols, idle included, and the block carries them to the output unchanged. This mode wins over every other input.

Control is a four-state machine. The states are ST_IDLE (emit IDLE), ST_DATA (emit the code for the stored nibble), ST_HALT (emit HALT) and ST_PASS (emit the stored 5-bit value unchanged). Every state can reach every state, and the inputs of each cycle choose the next state with a fixed priority. T_PASS (bypass high) goes to ST_PASS. Otherwise T_HALT (enable, error and 100 Mbps all high) goes to ST_HALT. Otherwise T_DATA (enable high) goes to ST_DATA. Otherwise T_IDLE goes to ST_IDLE. Reset puts the machine in ST_IDLE.

Top module: `tx4b5b_enc`

## Requirements
- R1: While reset is asserted, and until the first input has been registered, sym_out is the IDLE group 11111.
- R2: With bypass low and tx_en low, the next output is 11111, whatever the values of tx_nib, tx_err and spd_100.
- R3: With bypass low, tx_en high and no HALT condition, the next output is the code group for tx_nib. For nibbles 0 to F the code groups are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: With bypass low and spd_100, tx_en and tx_err all high, the next output is the HALT group 00100.
- R5: With spd_100 low (10 Mbps), tx_err has no effect: an enabled nibble gives its R3 code group, and HALT never appears unless bypass is high.
- R6: When tx_err is high and tx_en is low, with bypass low, the output is IDLE and not HALT.
- R7: With bypass high, the next output is {tx_err, tx_nib}, where tx_err is bit 4. This holds for any tx_en and spd_100.
- R8: Bypass takes priority over HALT. With bypass, tx_en, tx_err and spd_100 all high, the output is {1, tx_nib}.
- R9: The latency is exactly one clock. A change on the inputs between edges does not reach sym_out until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_nib | input | NIB_W | Transmit data nibble |
| tx_en | input | 1 | Marks the nibble as valid |
| tx_err | input | 1 | Error qualifier; used as bit 4 of the raw symbol in bypass |
| spd_100 | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps |
| bypass | input | 1 | 1 passes {tx_err, tx_nib} through without encoding |
| sym_out | output | NIB_W+1 | Registered 5-bit code group |

## Verification
Two functions can be requested in the same cycle: error substitution and raw pass-through. Both depend on tx_err, and the two give opposite results for it. The bench drives bypass, tx_en, tx_err and spd_100 all high together, for several nibbles, and expects the raw value with a 1 in bit 4 rather than 00100. A second collision is tx_err high at 10 Mbps with the enable high. There the bench expects the data code group and checks that HALT does not appear.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_HALT = 2'd2,
        ST_PASS = 2'd3
    } enc_state_e;

    localparam int          CODE_W    = 5;
    localparam logic [4:0]  SYM_IDLE  = 5'b11111;
    localparam logic [4:0]  SYM_HALT  = 5'b00100;

endpackage

// File: rtl/tx4b5b_lut.sv
module tx4b5b_lut (
    input  logic [3:0] nib,
    output logic [4:0] code
);

    always_comb begin
        unique case (nib)
            4'h0: code = 5'b11110;
            4'h1: code = 5'b01001;
            4'h2: code = 5'b10100;
            4'h3: code = 5'b10101;
            4'h4: code = 5'b01010;
            4'h5: code = 5'b01011;
            4'h6: code = 5'b01110;
            4'h7: code = 5'b01111;
            4'h8: code = 5'b10010;
            4'h9: code = 5'b10011;
            4'hA: code = 5'b10110;
            4'hB: code = 5'b10111;
            4'hC: code = 5'b11010;
            4'hD: code = 5'b11011;
            4'hE: code = 5'b11100;
            default: code = 5'b11101;
        endcase
    end

endmodule

// File: rtl/tx4b5b_ctl.sv
module tx4b5b_ctl
    import tx4b5b_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       tx_err,
    input  logic       spd_100,
    input  logic       bypass,
    output enc_state_e state_nx,
    output enc_state_e state_q
);

    // Next-state choice: pass-through, then halt, then data, then idle.
    always_comb begin
        if (bypass)
            state_nx = ST_PASS;
        else if (tx_en && tx_err && spd_100)
            state_nx = ST_HALT;
        else if (tx_en)
            state_nx = ST_DATA;
        else
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

endmodule

// File: rtl/tx4b5b_enc.sv
module tx4b5b_enc
    import tx4b5b_pkg::*;
#(
    parameter int NIB_W        = 4,
    parameter bit STORE_SYMBOL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] tx_nib,
    input  logic             tx_en,
    input  logic             tx_err,
    input  logic             spd_100,
    input  logic             bypass,
    output logic [NIB_W:0]   sym_out
);

    localparam int SYM_W = NIB_W + 1;

    enc_state_e state_q;
    enc_state_e state_nx;

    tx4b5b_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_err   (tx_err),
        .spd_100  (spd_100),
        .bypass   (bypass),
        .state_nx (state_nx),
        .state_q  (state_q)
    );

    generate
        if (STORE_SYMBOL) begin : g_sym_reg
            // Encode ahead of the register and keep the finished symbol.
            logic [SYM_W-1:0] code_in;
            logic [SYM_W-1:0] sym_d;
            logic [SYM_W-1:0] sym_q;

            tx4b5b_lut u_lut (
                .nib  (tx_nib[3:0]),
                .code (code_in)
            );

            always_comb begin
                unique case (state_nx)
                    ST_IDLE: sym_d = SYM_IDLE;
                    ST_DATA: sym_d = code_in;
                    ST_HALT: sym_d = SYM_HALT;
                    ST_PASS: sym_d = {tx_err, tx_nib};
                    default: sym_d = SYM_IDLE;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sym_q <= SYM_IDLE;
                else
                    sym_q <= sym_d;
            end

            always_comb sym_out = sym_q;
        end else begin : g_raw_reg
            // Keep the raw five bits and encode after the register.
            logic [SYM_W-1:0] raw_q;
            logic [SYM_W-1:0] code_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    raw_q <= SYM_IDLE;
                else
                    raw_q <= {tx_err, tx_nib};
            end

            tx4b5b_lut u_lut (
                .nib  (raw_q[3:0]),
                .code (code_q)
            );

            always_comb begin
                unique case (state_q)
                    ST_IDLE: sym_out = SYM_IDLE;
                    ST_DATA: sym_out = code_q;
                    ST_HALT: sym_out = SYM_HALT;
                    ST_PASS: sym_out = raw_q;
                    default: sym_out = SYM_IDLE;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/tx4b5b_enc_chk.sv
module tx4b5b_enc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] tx_nib,
    input logic       tx_en,
    input logic       tx_err,
    input logic       spd_100,
    input logic       bypass,
    input logic [4:0] sym_out
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> sym_out == 5'b11111);

    // R2
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(bypass) && !$past(tx_en) |-> sym_out == 5'b11111);

    // R4
    halt_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(bypass) && $past(tx_en) && $past(tx_err) && $past(spd_100)
        |-> sym_out == 5'b00100);

    // R5
    slow_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(bypass) && !$past(spd_100) |-> sym_out != 5'b00100);

    // R7
    raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(bypass) |-> sym_out == {$past(tx_err), $past(tx_nib)});

    // R8
    pass_over_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(bypass) && $past(tx_en) && $past(tx_err) && $past(spd_100)
        |-> sym_out[4]);

endmodule

bind tx4b5b_enc tx4b5b_enc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_nib  (tx_nib[3:0]),
    .tx_en   (tx_en),
    .tx_err  (tx_err),
    .spd_100 (spd_100),
    .bypass  (bypass),
    .sym_out (sym_out[4:0])
);

// File: tb/sim_tx4b5b_enc.sv
`timescale 1ns/1ps
module sim_tx4b5b_enc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tx_nib = 4'h0;
    logic       tx_en = 1'b0;
    logic       tx_err = 1'b0;
    logic       spd_100 = 1'b1;
    logic       bypass = 1'b0;
    logic [4:0] sym_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tx4b5b_enc u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_nib  (tx_nib),
        .tx_en   (tx_en),
        .tx_err  (tx_err),
        .spd_100 (spd_100),
        .bypass  (bypass),
        .sym_out (sym_out)
    );

    function automatic logic [4:0] ref_code(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, sample 1 ns later.
    task automatic step(input logic [3:0] n, input logic en, input logic er,
                        input logic sp, input logic bp);
        @(negedge clk);
        tx_nib = n; tx_en = en; tx_err = er; spd_100 = sp; bypass = bp;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        #1;
        check("R1 during reset", sym_out, 5'b11111);
        @(negedge clk);
        tx_nib = 4'h3; tx_en = 1'b1;
        #1;
        check("R1 reset ignores inputs", sym_out, 5'b11111);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", sym_out, 5'b11111);
    endtask

    task automatic t_idle;
        step(4'h5, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R2 idle 100M", sym_out, 5'b11111);
        step(4'hA, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 idle 10M", sym_out, 5'b11111);
    endtask

    task automatic t_map;
        for (int i = 0; i < 16; i++) begin
            step(4'(i), 1'b1, 1'b0, 1'b1, 1'b0);
            check($sformatf("R3 nibble %0h", i), sym_out, ref_code(4'(i)));
        end
    endtask

    task automatic t_halt;
        step(4'h7, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R4 halt", sym_out, 5'b00100);
        step(4'h0, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R4 halt nibble 0", sym_out, 5'b00100);
        step(4'h0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R4 data resumes", sym_out, ref_code(4'h0));
    endtask

    task automatic t_slow_err;
        for (int i = 0; i < 16; i++) begin
            step(4'(i), 1'b1, 1'b1, 1'b0, 1'b0);
            check($sformatf("R5 10M err nibble %0h", i), sym_out, ref_code(4'(i)));
        end
    endtask

    task automatic t_err_no_en;
        step(4'h9, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R6 err without enable", sym_out, 5'b11111);
    endtask

    task automatic t_pass;
        for (int i = 0; i < 32; i++) begin
            step(4'(i), 1'(i >> 1), 1'(i >> 4), 1'(i >> 2), 1'b1);
            check($sformatf("R7 raw %0d", i), sym_out, 5'(i));
        end
    endtask

    task automatic t_pass_prio;
        step(4'h2, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R8 bypass over halt", sym_out, 5'b10010);
        step(4'hF, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R8 bypass over halt F", sym_out, 5'b11111);
        step(4'h0, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R8 bypass over halt 0", sym_out, 5'b10000);
    endtask

    task automatic t_latency;
        step(4'h1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 first", sym_out, ref_code(4'h1));
        @(negedge clk);
        tx_nib = 4'hE;
        #1;
        check("R9 held between edges", sym_out, ref_code(4'h1));
        @(posedge clk);
        #1;
        check("R9 updated at edge", sym_out, ref_code(4'hE));
    endtask

    initial begin
        t_reset();
        t_idle();
        t_map();
        t_halt();
        t_slow_err();
        t_err_no_en();
        t_pass();
        t_pass_prio();
        t_latency();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule